// File: doc/BRIEF.md
# Branch Hazard Fetch Controller

This block steers the fetch address of a five-stage in-order pipeline and owns the valid bit of the fetch-to-decode register. Branches are resolved in decode, by testing a register against zero. When decode holds a branch, the block receives three things: a branch flag, the outcome of the branch, and the target address. In that same cycle it decides what fetch does next, using one of three static policies that a mode input selects.

The three policies behave differently. Under freeze, fetch does not advance while the branch sits in decode, so every branch costs one bubble. Under predict-not-taken, sequential fetch continues. A taken branch then throws away the wrong-path instruction that was just fetched by clearing its valid bit, so it reaches decode as a bubble and can write no register or memory. Under delayed branch, the instruction after the branch is a delay slot. It always proceeds, and fetch then jumps or falls through with no bubble. The mode may change only in a cycle with no branch in decode. The fourth mode code would mean predict-taken, which is not supported, so it falls back to freeze.

Top module: `bfc_fetch_ctrl`

## Requirements
- R1: While reset is asserted, fetch_pc_o equals the reset address (default 0), ifid_valid_o is 0, and fetch_stall_o and squash_o are 0.
- R2: In a cycle with no effective branch, the fetch address advances by one instruction (4 bytes), and ifid_valid_o is 1 in the next cycle.
- R3: Freeze (mode 0). An effective branch raises fetch_stall_o and loads a bubble into the fetch-to-decode register. The next fetch address is the target if the branch is taken, or the unchanged current address if it is not. Exactly one cycle is lost in both cases.
- R4: Predict-not-taken (mode 1). A not-taken branch raises neither fetch_stall_o nor squash_o. Fetch advances by 4 and no cycle is lost.
- R5: Predict-not-taken (mode 1). A taken branch raises squash_o, and the instruction fetched in that cycle enters decode with its valid bit cleared. The next fetch address is the target, and exactly one cycle is lost.
- R6: Delayed branch (mode 2). The delay-slot instruction always enters decode valid, and neither fetch_stall_o nor squash_o rises. The next fetch address is the target if taken, or current+4 if not. No cycle is lost.
- R7: Mode code 3 (predict-taken, unsupported) behaves exactly as freeze.
- R8: fetch_stall_o and squash_o are never high together. squash_o rises only for a taken branch in mode 1.
- R9: next_pc_o always equals the value fetch_pc_o takes after the next clock edge.
- R10: A branch flag that arrives while ifid_valid_o is 0 is ignored: fetch advances by 4 and there is no stall and no squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Branch policy: 0 freeze, 1 predict-not-taken, 2 delayed, 3 reserved (acts as freeze) |
| dec_branch_i | input | 1 | Decode holds a conditional branch |
| br_taken_i | input | 1 | Outcome of the branch in decode |
| br_target_i | input | ADDR_W | Target address of the branch in decode |
| fetch_pc_o | output | ADDR_W | Address fetched this cycle |
| next_pc_o | output | ADDR_W | Address to be fetched next cycle |
| fetch_stall_o | output | 1 | Fetch held this cycle; its instruction becomes a bubble |
| squash_o | output | 1 | Wrong-path instruction fetched this cycle is discarded |
| ifid_valid_o | output | 1 | Valid bit of the fetch-to-decode register |

## Verification
The bench targets the not-taken cases of freeze, the taken case of predict-not-taken, and the taken delay slot. A design that mishandles freeze not-taken skips an instruction instead of re-fetching it. A wrong predict-not-taken would let the wrong-path instruction reach decode valid, or would stall without redirecting. A wrong delayed mode would kill the delay slot and so lose a cycle. The bench also sends branch flags on bubbles and uses the reserved mode code. A controller that acts on those flags, or treats code 3 as a prediction, shows the wrong fetch address or the wrong bubble count. Directed runs count the bubbles that follow each branch in every mode, and the random stream checks every output in every cycle.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    typedef enum logic [1:0] {
        POL_FREEZE = 2'd0,
        POL_PNT    = 2'd1,
        POL_DELAY  = 2'd2,
        POL_RSVD   = 2'd3
    } policy_e;

    typedef struct packed {
        logic hold;      // keep fetch address, bubble into decode
        logic redirect;  // next fetch address is the branch target
        logic kill;      // discard instruction fetched this cycle
    } action_t;

endpackage

// File: rtl/bfc_policy.sv
module bfc_policy
    import bfc_pkg::*;
(
    input  policy_e mode_i,
    input  logic    branch_i,
    input  logic    taken_i,
    output action_t act_o
);

    action_t act_d;

    always_comb begin
        act_d = '0;
        if (branch_i) begin
            unique case (mode_i)
                POL_PNT: begin
                    act_d.redirect = taken_i;
                    act_d.kill     = taken_i;
                end
                POL_DELAY: begin
                    act_d.redirect = taken_i;
                end
                default: begin
                    act_d.hold     = 1'b1;
                    act_d.redirect = taken_i;
                end
            endcase
        end
    end

    assign act_o = act_d;

    // R8
    always_comb begin
        stall_squash_excl_chk: assert (!(act_o.hold && act_o.kill));
    end

endmodule

// File: rtl/bfc_pc_seq.sv
module bfc_pc_seq
    import bfc_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          STEP     = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  action_t           act_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              vld_o
);

    localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(STEP);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              vld;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (act_i.redirect) begin
            st_d.pc = target_i;
        end else if (act_i.hold) begin
            st_d.pc = st_q.pc;
        end else begin
            st_d.pc = st_q.pc + STEP_W;
        end
        st_d.vld = !(act_i.hold || act_i.kill);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.pc  <= RESET_PC;
            st_q.vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o      = st_q.pc;
    assign next_pc_o = st_d.pc;
    assign vld_o     = st_q.vld;

    // R2
    seq_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!act_i.hold && !act_i.redirect) |=> (pc_o == $past(pc_o) + STEP_W));

    // R5
    kill_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_i.kill |=> !vld_o);

    // R3
    hold_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_i.hold && !act_i.redirect) |=> (!vld_o && pc_o == $past(pc_o)));

endmodule

// File: rtl/bfc_fetch_ctrl.sv
module bfc_fetch_ctrl
    import bfc_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          STEP     = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        mode_i,
    input  logic              dec_branch_i,
    input  logic              br_taken_i,
    input  logic [ADDR_W-1:0] br_target_i,
    output logic [ADDR_W-1:0] fetch_pc_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              fetch_stall_o,
    output logic              squash_o,
    output logic              ifid_valid_o
);

    policy_e mode;
    logic    eff_branch;
    action_t act;

    assign mode       = policy_e'(mode_i);
    assign eff_branch = dec_branch_i && ifid_valid_o;   // R10

    bfc_policy u_policy (
        .mode_i   (mode),
        .branch_i (eff_branch),
        .taken_i  (br_taken_i),
        .act_o    (act)
    );

    bfc_pc_seq #(
        .ADDR_W   (ADDR_W),
        .STEP     (STEP),
        .RESET_PC (RESET_PC)
    ) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .act_i     (act),
        .target_i  (br_target_i),
        .pc_o      (fetch_pc_o),
        .next_pc_o (next_pc_o),
        .vld_o     (ifid_valid_o)
    );

    assign fetch_stall_o = act.hold;
    assign squash_o      = act.kill;

    // R6
    delay_slot_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eff_branch && mode == POL_DELAY) |=> ifid_valid_o);

    // R4
    pnt_fallthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eff_branch && mode == POL_PNT && !br_taken_i) |=> ifid_valid_o);

    // R5
    taken_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eff_branch && br_taken_i) |=> (fetch_pc_o == $past(br_target_i)));

    // R8
    squash_only_pnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        squash_o |-> (mode == POL_PNT && br_taken_i));

    // R10
    bubble_flag_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ifid_valid_o) |-> (!fetch_stall_o && !squash_o));

endmodule

// File: tb/bfc_fetch_ctrl_tb.sv
module bfc_fetch_ctrl_tb;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          brn = 1'b0;
    logic          tkn = 1'b0;
    logic [AW-1:0] tgt = '0;
    logic [AW-1:0] pc, npc;
    logic          stall, squash, vld;

    int n_chk = 0;
    int n_err = 0;

    logic [AW-1:0] exp_pc;
    logic          exp_vld;
    logic          obs_vld;

    always #5 clk = ~clk;

    bfc_fetch_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dec_branch_i(brn),
        .br_taken_i(tkn), .br_target_i(tgt), .fetch_pc_o(pc),
        .next_pc_o(npc), .fetch_stall_o(stall), .squash_o(squash),
        .ifid_valid_o(vld)
    );

    task automatic chk(input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic is_freeze(input logic [1:0] m);
        return (m == 2'd0) || (m == 2'd3);
    endfunction

    function automatic string tag_of(input logic [1:0] m, input logic eff, input logic t,
                                     input logic b);
        if (!eff) return b ? "R10" : "R2";
        if (m == 2'd3) return "R7";
        if (m == 2'd0) return "R3";
        if (m == 2'd2) return "R6";
        return t ? "R5" : "R4";
    endfunction

    // one cycle: drive, check combinational outputs, advance model
    task automatic step(input logic [1:0] m, input logic b, input logic t,
                        input logic [AW-1:0] target);
        logic eff, e_stall, e_sq;
        logic [AW-1:0] e_next;
        string tg;
        @(negedge clk);
        mode = m; brn = b; tkn = t; tgt = target;
        #1;
        eff     = b && exp_vld;
        e_stall = eff && is_freeze(m);
        e_sq    = eff && (m == 2'd1) && t;
        e_next  = (eff && t) ? target : (e_stall ? exp_pc : exp_pc + 32'd4);
        tg      = tag_of(m, eff, t, b);
        chk(tg, "fetch_pc", pc, exp_pc);
        chk(tg, "ifid_valid", {31'd0, vld}, {31'd0, exp_vld});
        chk(tg, "fetch_stall", {31'd0, stall}, {31'd0, e_stall});
        chk(tg, "squash", {31'd0, squash}, {31'd0, e_sq});
        chk("R9", "next_pc", npc, e_next);
        if (stall && squash) chk("R8", "stall_and_squash", 32'd1, 32'd0);
        obs_vld = vld;
        @(posedge clk);
        exp_pc  = e_next;
        exp_vld = !(e_stall || e_sq);
    endtask

    // directed: one branch, then count bubbles seen in decode
    task automatic run_branch(input logic [1:0] m, input logic t, input int exp_lost,
                              input string tag);
        int lost = 0;
        for (int i = 0; i < 3; i++) step(m, 1'b0, 1'b0, '0);
        step(m, 1'b1, t, 32'h0000_4000);
        for (int i = 0; i < 3; i++) begin
            step(m, 1'b0, 1'b0, '0);
            if (!obs_vld) lost++;
        end
        chk(tag, "lost_cycles", 32'(lost), 32'(exp_lost));
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        int seed;
        logic [1:0] m;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "fetch_pc", pc, '0);
        chk("R1", "ifid_valid", {31'd0, vld}, 32'd0);
        chk("R1", "fetch_stall", {31'd0, stall}, 32'd0);
        chk("R1", "squash", {31'd0, squash}, 32'd0);
        rst_n = 1'b1;
        exp_pc = '0; exp_vld = 1'b0;
        @(posedge clk);
        exp_pc = 32'd4; exp_vld = 1'b1;

        // directed lost-cycle counts per policy and outcome
        run_branch(2'd0, 1'b0, 1, "R3");
        run_branch(2'd0, 1'b1, 1, "R3");
        run_branch(2'd1, 1'b0, 0, "R4");
        run_branch(2'd1, 1'b1, 1, "R5");
        run_branch(2'd2, 1'b0, 0, "R6");
        run_branch(2'd2, 1'b1, 0, "R6");
        run_branch(2'd3, 1'b0, 1, "R7");
        run_branch(2'd3, 1'b1, 1, "R7");

        // branch flag on a bubble (after a freeze branch)
        step(2'd0, 1'b1, 1'b0, '0);
        step(2'd0, 1'b1, 1'b1, 32'h0000_8000);  // R10: ignored
        step(2'd0, 1'b0, 1'b0, '0);

        // constrained random, mode changes only on a no-branch cycle
        for (int blk = 0; blk < 100; blk++) begin
            m = 2'($urandom_range(0, 3));
            step(m, 1'b0, 1'b0, '0);
            for (int c = 0; c < 20; c++) begin
                step(m, ($urandom_range(0, 2) == 0), 1'($urandom),
                     {$urandom} & 32'hFFFF_FFFC);
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule